// File: doc/BRIEF.md
# Video Sync Source Selector and Clamp/Coast Controller

This block sits in the digital front end of a video capture path, between the raw sync inputs and the pixel pipeline. It has two horizontal sync sources, a dedicated Hsync line and a sync recovered from the green channel, and picks one. It also has two vertical sync sources, a Vsync line and the output of a composite sync separator, and picks one of those. In each case the choice is made automatically from activity-detect flags, or fixed by an override field in its small control register bank. The chosen syncs leave with a programmable polarity or inversion. Every sync input is taken to be normalised active-high before it arrives.

The block also produces the clamp strobe for the analog input stage. The strobe comes either from an internal pixel-clock timer, started on the leading edge of the chosen Hsync, or from an external clamp pin of programmable active level. A coast strobe is taken either from a dedicated pin or from the chosen vertical sync.

The control registers are written through a simple strobe/address/data port. All five outputs are registered. A change on a sync input reaches the outputs one clock later. A change in activity flags or control fields reaches the outputs two clocks later, because the source choice is itself registered.

Top module: `sync_cond_top`

## Requirements
- R1: After reset the control fields hold their defaults. Both sync overrides are off, Hsync polarity is active-low, Vsync inversion is off, the clamp source is internal, the external clamp is low-active, coast comes from the pin, and placement and duration are 0. As a result, hs_out and sog_out are high while their sources are low, vs_out follows the chosen vertical source, coast_out follows coast_pin, and clamp_out stays low.
- R2: With the Hsync override off and exactly one Hsync source active, that source becomes the chosen one (hs_act selects hs_in, sog_act selects sog_in).
- R3: With the override off and both Hsync sources active, the Hsync select field (sync control bit 1) decides: 0 picks hs_in, 1 picks sog_in.
- R4: With the override off and neither source active, the previous Hsync choice is kept.
- R5: With the Hsync override field set (sync control bit 0), the select field alone picks the source, whatever the activity flags say.
- R6: The vertical source follows the same scheme. The override is sync control bit 3 and the select is bit 4, where 0 picks vs_in and 1 picks sep_vs_in. In automatic mode with both sources active, vs_in is preferred.
- R7: The Hsync polarity field (sync control bit 2) sets the output level of both hs_out and sog_out. A value of 1 gives active-high (the source passed through) and 0 gives active-low (the source inverted).
- R8: When the Vsync invert field (sync control bit 5) is 1, vs_out is the complement of the chosen vertical source. When it is 0, vs_out is the source unchanged.
- R9: With the internal clamp selected (clamp control bit 0 = 0), a rising edge of the chosen Hsync that is registered on clock edge E drives clamp_out high. clamp_out is high after clock edges E+P+2 through E+P+D+1, where P is the placement register (address 2) and D is the duration register (address 3).
- R10: A duration of 0 produces no internal clamp pulse. A new rising Hsync edge restarts the placement count from zero.
- R11: With the external clamp selected (clamp control bit 0 = 1), clamp_out equals clamp_pin, inverted when clamp control bit 1 (low-active) is 1. The output arrives one clock after the pin.
- R12: Clamp control bit 2 selects the coast source: 0 takes coast_pin and 1 takes the chosen vertical source before inversion. The output arrives one clock after its source.
- R13: A write with wr_en high updates one register on the clock edge: address 0 is sync control, 1 is clamp control, 2 is placement and 3 is duration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | CNT_W | Register write data |
| hs_in | input | 1 | Dedicated Hsync, active-high |
| sog_in | input | 1 | Sync recovered from green, active-high |
| hs_act | input | 1 | Activity seen on hs_in |
| sog_act | input | 1 | Activity seen on sog_in |
| vs_in | input | 1 | Dedicated Vsync, active-high |
| sep_vs_in | input | 1 | Sync separator vertical output, active-high |
| vs_act | input | 1 | Activity seen on vs_in |
| sep_act | input | 1 | Activity seen on sep_vs_in |
| clamp_pin | input | 1 | External clamp request |
| coast_pin | input | 1 | External coast request |
| hs_out | output | 1 | Chosen Hsync with programmed polarity |
| sog_out | output | 1 | Green-derived sync with programmed polarity |
| vs_out | output | 1 | Chosen Vsync with optional inversion |
| clamp_out | output | 1 | Clamp strobe, active-high |
| coast_out | output | 1 | Coast strobe, active-high |

## Verification
The bench drives both activity flags low after an automatic choice has been made. A design that falls back to a fixed source there, instead of holding its choice, flips hs_out. With both flags high it toggles the select field, which catches a tie broken by a constant. Under override it drives activity that contradicts the select field, which catches a design that lets activity win. The internal clamp is traced cycle by cycle, so a window that is off by one at either end is seen, as is a pulse produced by a zero duration, or a restart that leaks a cycle of the abandoned window. Both levels of the external clamp are checked, and coast is checked from the Vsync path, where coast must not follow the invert field.

// File: rtl/sync_cond_pkg.sv
// Shared register layout for the sync selection and clamp controller.
// Assumes registers are CNT_W wide with CNT_W >= 6.
package sync_cond_pkg;

    typedef enum logic [1:0] {
        ADR_SYNC  = 2'd0,
        ADR_CLAMP = 2'd1,
        ADR_PLACE = 2'd2,
        ADR_DUR   = 2'd3
    } reg_adr_e;

    // Sync control word, bit 0 = hs_ovr up to bit 5 = vs_inv.
    typedef struct packed {
        logic vs_inv;
        logic vs_sel;
        logic vs_ovr;
        logic hs_pol;
        logic hs_sel;
        logic hs_ovr;
    } sync_ctl_t;

    // Clamp control word, bit 0 = clamp_ext up to bit 2 = coast_vs.
    typedef struct packed {
        logic coast_vs;
        logic clamp_lowact;
        logic clamp_ext;
    } clamp_ctl_t;

endpackage

// File: rtl/sync_ctl_regs.sv
// Control register bank: four write-only words updated by a single
// strobe/address/data port. Assumes CNT_W >= 6 so the sync word fits.
module sync_ctl_regs
    import sync_cond_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output sync_ctl_t        sync_ctl,
    output clamp_ctl_t       clamp_ctl,
    output logic [CNT_W-1:0] place,
    output logic [CNT_W-1:0] dur
);
    localparam int SYNC_W  = $bits(sync_ctl_t);
    localparam int CLAMP_W = $bits(clamp_ctl_t);

    // Load the addressed word on a write; defaults on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_ctl  <= '0;
            clamp_ctl <= '{coast_vs: 1'b0, clamp_lowact: 1'b1, clamp_ext: 1'b0};
            place     <= '0;
            dur       <= '0;
        end else if (wr_en) begin
            case (reg_adr_e'(wr_addr))
                ADR_SYNC:  sync_ctl  <= sync_ctl_t'(wr_data[SYNC_W-1:0]);
                ADR_CLAMP: clamp_ctl <= clamp_ctl_t'(wr_data[CLAMP_W-1:0]);
                ADR_PLACE: place     <= wr_data;
                default:   dur       <= wr_data;
            endcase
        end
    end

endmodule

// File: rtl/sync_src_pick.sv
// Two-way sync source chooser. pick = 0 means primary, 1 means alternate.
// Override forces sel; otherwise a lone active source wins, a tie is
// resolved per TIE_BY_SEL (sel, or primary), and no activity holds.
module sync_src_pick #(
    parameter bit TIE_BY_SEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prim_act,
    input  logic alt_act,
    input  logic ovr,
    input  logic sel,
    output logic pick
);
    logic tie_pick;
    logic pick_nxt;

    generate
        if (TIE_BY_SEL) begin : g_tie_sel
            assign tie_pick = sel;
        end else begin : g_tie_prim
            assign tie_pick = 1'b0;
        end
    endgenerate

    // Decide the next choice from override and activity.
    always_comb begin
        if (ovr) begin
            pick_nxt = sel;
        end else begin
            case ({prim_act, alt_act})
                2'b11:   pick_nxt = tie_pick;
                2'b10:   pick_nxt = 1'b0;
                2'b01:   pick_nxt = 1'b1;
                default: pick_nxt = pick;
            endcase
        end
    end

    // Hold the current choice.
    always_ff @(posedge clk) begin
        if (!rst_n) pick <= 1'b0;
        else        pick <= pick_nxt;
    end

    // R5
    ovr_follows_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |=> (pick == $past(sel)));
    // R2
    lone_prim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr && prim_act && !alt_act) |=> !pick);
    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr && !prim_act && !alt_act) |=> $stable(pick));

endmodule

// File: rtl/clamp_timer.sv
// Internal clamp generator: detects the rising edge of the chosen
// (active-high) Hsync, counts pixel clocks and raises pulse_q for dur
// clocks starting place clocks after the edge. A new edge restarts it.
module clamp_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_in,
    input  logic [CNT_W-1:0] place,
    input  logic [CNT_W-1:0] dur,
    output logic             pulse_q
);
    localparam int                SPAN_W = CNT_W + 1;
    localparam logic [SPAN_W-1:0] SAT    = '1;

    logic              sync_d;
    logic              armed;
    logic [SPAN_W-1:0] cnt;
    logic [SPAN_W-1:0] win_lo;
    logic [SPAN_W-1:0] win_hi;
    logic              lead;
    logic              in_win;

    assign lead   = sync_in & ~sync_d;
    assign win_lo = {1'b0, place};
    assign win_hi = {1'b0, place} + {1'b0, dur};
    assign in_win = armed && (cnt >= win_lo) && (cnt < win_hi);

    // Delay the sync by one clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_d <= 1'b0;
        else        sync_d <= sync_in;
    end

    // Restart on an edge, otherwise count up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (lead) begin
            armed <= 1'b1;
            cnt   <= '0;
        end else if (armed && cnt != SAT) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Register the window decode.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= in_win;
    end

    // R10
    zero_dur_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(dur) == '0) |-> !pulse_q);
    // R10
    edge_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lead |=> (armed && cnt == '0));

endmodule

// File: rtl/sync_cond_top.sv
// Sync source selection, polarity conditioning, clamp and coast control.
// Assumes all sync inputs and activity flags are already synchronous to
// clk and that syncs are normalised active-high.
module sync_cond_top
    import sync_cond_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             hs_in,
    input  logic             sog_in,
    input  logic             hs_act,
    input  logic             sog_act,
    input  logic             vs_in,
    input  logic             sep_vs_in,
    input  logic             vs_act,
    input  logic             sep_act,
    input  logic             clamp_pin,
    input  logic             coast_pin,
    output logic             hs_out,
    output logic             sog_out,
    output logic             vs_out,
    output logic             clamp_out,
    output logic             coast_out
);
    sync_ctl_t        sync_ctl;
    clamp_ctl_t       clamp_ctl;
    logic [CNT_W-1:0] place;
    logic [CNT_W-1:0] dur;
    logic             hs_pick;
    logic             vs_pick;
    logic             hs_src;
    logic             vs_src;
    logic             int_pulse;

    sync_ctl_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sync_ctl  (sync_ctl),
        .clamp_ctl (clamp_ctl),
        .place     (place),
        .dur       (dur)
    );

    sync_src_pick #(.TIE_BY_SEL(1'b1)) u_hs_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .prim_act (hs_act),
        .alt_act  (sog_act),
        .ovr      (sync_ctl.hs_ovr),
        .sel      (sync_ctl.hs_sel),
        .pick     (hs_pick)
    );

    sync_src_pick #(.TIE_BY_SEL(1'b0)) u_vs_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .prim_act (vs_act),
        .alt_act  (sep_act),
        .ovr      (sync_ctl.vs_ovr),
        .sel      (sync_ctl.vs_sel),
        .pick     (vs_pick)
    );

    assign hs_src = hs_pick ? sog_in : hs_in;
    assign vs_src = vs_pick ? sep_vs_in : vs_in;

    clamp_timer #(.CNT_W(CNT_W)) u_clamp (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_in (hs_src),
        .place   (place),
        .dur     (dur),
        .pulse_q (int_pulse)
    );

    // Register the conditioned outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_out    <= 1'b0;
            sog_out   <= 1'b0;
            vs_out    <= 1'b0;
            clamp_out <= 1'b0;
            coast_out <= 1'b0;
        end else begin
            hs_out    <= sync_ctl.hs_pol ? hs_src : ~hs_src;
            sog_out   <= sync_ctl.hs_pol ? sog_in : ~sog_in;
            vs_out    <= vs_src ^ sync_ctl.vs_inv;
            clamp_out <= clamp_ctl.clamp_ext ? (clamp_pin ^ clamp_ctl.clamp_lowact)
                                             : int_pulse;
            coast_out <= clamp_ctl.coast_vs ? vs_src : coast_pin;
        end
    end

    // R11
    ext_clamp_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(clamp_ctl.clamp_ext))
        |-> (clamp_out == ($past(clamp_pin) ^ $past(clamp_ctl.clamp_lowact))));
    // R12
    coast_pin_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(clamp_ctl.coast_vs)) |-> (coast_out == $past(coast_pin)));
    // R7
    sog_active_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sync_ctl.hs_pol)) |-> (sog_out == $past(sog_in)));

endmodule

// File: tb/sync_cond_top_test.sv
module sync_cond_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;
    localparam int O_HS = 0, O_SOG = 1, O_VS = 2, O_CLAMP = 3, O_COAST = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [CNT_W-1:0] wr_data = '0;
    logic hs_in = 0, sog_in = 0, hs_act = 0, sog_act = 0;
    logic vs_in = 0, sep_vs_in = 0, vs_act = 0, sep_act = 0;
    logic clamp_pin = 0, coast_pin = 0;
    logic hs_out, sog_out, vs_out, clamp_out, coast_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        string req;
        int    idx;
        logic  exp;
    } item_t;
    item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_cond_top #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hs_in(hs_in), .sog_in(sog_in), .hs_act(hs_act), .sog_act(sog_act),
        .vs_in(vs_in), .sep_vs_in(sep_vs_in), .vs_act(vs_act), .sep_act(sep_act),
        .clamp_pin(clamp_pin), .coast_pin(coast_pin),
        .hs_out(hs_out), .sog_out(sog_out), .vs_out(vs_out),
        .clamp_out(clamp_out), .coast_out(coast_out)
    );

    // Monitor: pops expected items and compares a quarter period after negedge.
    initial begin
        item_t it;
        logic [4:0] obs;
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            obs = {coast_out, clamp_out, vs_out, sog_out, hs_out};
            while (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                checks++;
                if (obs[it.idx] !== it.exp) begin
                    failures++;
                    $display("FAIL %s output#%0d actual=%b expected=%b at %0t",
                             it.req, it.idx, obs[it.idx], it.exp, $time);
                end
            end
        end
    end

    task automatic expect_o(input string req, input int idx, input logic exp);
        item_t it;
        it.req = req; it.idx = idx; it.exp = exp;
        sb_q.push_back(it);
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [CNT_W-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        cyc(3);
    endtask

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(3);
        // R1 defaults: active-low Hsync, no Vsync invert, coast from pin, no clamp
        expect_o("R1", O_HS, 1'b1);
        expect_o("R1", O_SOG, 1'b1);
        expect_o("R1", O_VS, 1'b0);
        expect_o("R1", O_CLAMP, 1'b0);
        expect_o("R1", O_COAST, 1'b0);
        cyc(1);
        coast_pin = 1; vs_in = 1; hs_act = 1;
        cyc(3);
        expect_o("R1", O_COAST, 1'b1);
        expect_o("R1", O_VS, 1'b1);
        cyc(1);
        // R1 / R10: zero default duration gives no clamp on an Hsync edge
        hs_in = 1;
        for (int k = 1; k <= 10; k++) begin
            cyc(1);
            expect_o("R10", O_CLAMP, 1'b0);
        end
        hs_in = 0; cyc(2);

        // R11 / R13: external clamp, default low-active
        wr(2'd1, 8'h03);
        clamp_pin = 0; cyc(2); expect_o("R11", O_CLAMP, 1'b1);
        cyc(1); clamp_pin = 1; cyc(2); expect_o("R11", O_CLAMP, 1'b0);
        cyc(1);
        wr(2'd1, 8'h01);
        clamp_pin = 1; cyc(2); expect_o("R11", O_CLAMP, 1'b1);
        cyc(1); clamp_pin = 0; cyc(2); expect_o("R11", O_CLAMP, 1'b0);
        cyc(1);

        // R7: active-high polarity on both outputs
        wr(2'd0, 8'h04);
        hs_in = 1; sog_in = 0; cyc(2);
        expect_o("R7", O_HS, 1'b1); expect_o("R7", O_SOG, 1'b0);
        cyc(1); hs_in = 0; sog_in = 1; cyc(2);
        expect_o("R7", O_HS, 1'b0); expect_o("R7", O_SOG, 1'b1);
        cyc(1);

        // R2: only green-derived sync active
        hs_act = 0; sog_act = 1; cyc(3);
        expect_o("R2", O_HS, 1'b1);
        cyc(1);
        // R4: no activity holds the green choice
        hs_act = 0; sog_act = 0; sog_in = 0; hs_in = 1; cyc(3);
        expect_o("R4", O_HS, 1'b0);
        cyc(1);
        // R3: both active, select decides
        hs_act = 1; sog_act = 1; cyc(3);
        expect_o("R3", O_HS, 1'b1);
        cyc(1);
        wr(2'd0, 8'h06);
        expect_o("R3", O_HS, 1'b0);
        cyc(1);
        // R5: override beats activity
        sog_act = 0;
        wr(2'd0, 8'h07);
        expect_o("R5", O_HS, 1'b0);
        cyc(1);
        hs_act = 0; sog_act = 1;
        wr(2'd0, 8'h05);
        expect_o("R5", O_HS, 1'b1);
        cyc(1);

        // R6: vertical source choice
        vs_in = 0; sep_vs_in = 1; vs_act = 0; sep_act = 1; cyc(3);
        expect_o("R6", O_VS, 1'b1);
        cyc(1); vs_act = 1; cyc(3);
        expect_o("R6", O_VS, 1'b0);
        cyc(1);
        wr(2'd0, 8'h1D);
        expect_o("R6", O_VS, 1'b1);
        cyc(1);
        // R8: invert
        wr(2'd0, 8'h3D);
        expect_o("R8", O_VS, 1'b0);
        cyc(1);

        // R12: coast from the chosen Vsync, ignoring the invert field
        coast_pin = 0;
        wr(2'd1, 8'h05);
        expect_o("R12", O_COAST, 1'b1);
        cyc(1); sep_vs_in = 0; cyc(2);
        expect_o("R12", O_COAST, 1'b0);
        cyc(1);

        // R9: internal clamp window, place 3 dur 4, Hsync input forced
        wr(2'd1, 8'h02);
        wr(2'd2, 8'd3);
        wr(2'd3, 8'd4);
        hs_in = 0; cyc(2);
        hs_in = 1;
        for (int k = 1; k <= 14; k++) begin
            cyc(1);
            expect_o("R9", O_CLAMP, (k >= 6 && k <= 9) ? 1'b1 : 1'b0);
        end
        hs_in = 0; cyc(2);

        // R10: restart, place 2 dur 6, new edge registered on clock 3
        wr(2'd2, 8'd2);
        wr(2'd3, 8'd6);
        hs_in = 1;
        for (int k = 1; k <= 15; k++) begin
            cyc(1);
            if (k == 1) hs_in = 0;
            if (k == 2) hs_in = 1;
            expect_o("R10", O_CLAMP, (k >= 7 && k <= 12) ? 1'b1 : 1'b0);
        end
        hs_in = 0; cyc(2);

        // R10: zero duration after programming
        wr(2'd3, 8'd0);
        hs_in = 1;
        for (int k = 1; k <= 8; k++) begin
            cyc(1);
            expect_o("R10", O_CLAMP, 1'b0);
        end

        cyc(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule